// File: doc/BRIEF.md
# Programmable Clock Divider with Control Word

This block derives a slower clock from its input clock. The divide ratio sits in a bit field of a 16-bit control word. Software writes the word over a plain write port and can read it back. The position and width of the field are fixed by parameters. A static mode parameter picks how the field value is turned into a divisor:

- field plus one;
- the raw value, counting from one;
- two raised to the field value;
- a short lookup table of value and divisor pairs.

A divisor of one passes the input clock straight through. A setting that maps to no usable divisor raises a flag and holds the divided output low.

Writes follow one of two masking schemes. In byte mode, two byte enables choose which halves of the word change. In word-mask mode, the upper 16 bits of the write data act as a per-bit enable for the lower 16. A read-only option freezes the divider field while the other control bits stay writable.

A newly written divisor never cuts short the output period in progress. It is loaded when the current period ends, so the output never shows a runt pulse.

Top module: `clkdiv_reg`

## Requirements
- R1: In the field-plus-one mode the divisor N is the field value plus 1. For N of 2 or more, each output period lasts N input cycles, of which the first floor(N/2) are high. N equal to 1 passes the input clock through to `clk_out`.
- R2: In the one-based mode with zero divisors disallowed, N equals the field value. A field of 0 sets `bad_cfg` to 1 and holds `clk_out` low.
- R3: In the one-based mode with zero divisors allowed, a field of 0 passes the input clock through and keeps `bad_cfg` at 0.
- R4: In the power-of-two mode, N is 2 raised to the field value, so a field of 0 gives pass-through. A field of DIV_W or more is invalid.
- R5: In the table mode, the field value is looked up among the table entries from index 0 upward. The search stops at the first entry whose divisor is 0. A value found before that entry gives its divisor; any other value sets `bad_cfg` and holds the output low.
- R6: The field occupies control bits [SHIFT+WIDTH-1:SHIFT], which is [7:4] with the defaults. All other control bits are plain storage.
- R7: In byte mode, a write with `wr_be[0]` set updates control bits [7:0]. A write with `wr_be[1]` set updates bits [15:8]. A byte whose enable is clear keeps its value.
- R8: In word-mask mode, control bit i (0 to 15) takes `wr_data[i]` only when `wr_data[16+i]` is 1 in the same write. `wr_be` is ignored in this mode.
- R9: In read-only mode, writes leave the divider field unchanged and still update the other control bits.
- R10: A change of divisor takes effect only after the output period in progress has completed with its old high and low lengths.
- R11: While `rst_n` is low, `clk_out` is low and the control word equals RST_VAL.
- R12: `rd_data[15:0]` returns the control word, and `rd_data[31:16]` reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, divided and also the register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 2 | Byte enables for the low and high byte (byte mode only) |
| wr_data | input | 32 | Write data; bits [31:16] are the bit mask in word-mask mode |
| rd_data | output | 32 | Control word in [15:0], zeros above |
| clk_out | output | 1 | Divided clock, or the input clock when N is 1 |
| bad_cfg | output | 1 | The active setting decodes to no valid divisor |

## Verification
The bench exercises all four decoding modes, each on its own instance, with random field values mixed with other control bits. For each value it measures both the high and low lengths of a full period. This separates an off-by-one in the divisor from an error in the odd-divisor duty cycle, and it separates pass-through from a stuck output.

Several cases are directed:
- a field of zero under both zero rules;
- a table value placed after the terminator, which shows that the search stops there rather than scanning the whole table;
- a rewrite in the middle of a high phase, which shows whether the old period completes.

Random word-mask writes and partial byte enables check that unmasked bits hold. A write to a read-only instance checks that only the field is frozen.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    DEC_PLUS1    = 2'd0,
    DEC_ONEBASED = 2'd1,
    DEC_POW2     = 2'd2,
    DEC_TABLE    = 2'd3
  } dec_mode_e;

  localparam int CTRL_W = 16;
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
  import clkdiv_pkg::*;
#(
  parameter int                SHIFT     = 4,
  parameter int                WIDTH     = 4,
  parameter bit                HIWORD    = 1'b0,
  parameter bit                READ_ONLY = 1'b0,
  parameter logic [CTRL_W-1:0] RST_VAL   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam logic [CTRL_W-1:0] FIELD_MASK = CTRL_W'(((1 << WIDTH) - 1) << SHIFT);

  logic [CTRL_W-1:0] wmask;
  logic [CTRL_W-1:0] ctrl_nxt;

  generate
    if (HIWORD) begin : g_hiword
      assign wmask = wr_data[31:16] & (READ_ONLY ? ~FIELD_MASK : '1);
    end else begin : g_bytes
      assign wmask = {{8{wr_be[1]}}, {8{wr_be[0]}}} & (READ_ONLY ? ~FIELD_MASK : '1);
    end
  endgenerate

  assign ctrl_nxt = (ctrl_q & ~wmask) | (wr_data[CTRL_W-1:0] & wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= RST_VAL;
    else if (wr_en) ctrl_q <= ctrl_nxt;
  end
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter dec_mode_e                      MODE       = DEC_PLUS1,
  parameter int                             WIDTH      = 4,
  parameter int                             DIV_W      = 16,
  parameter bit                             ALLOW_ZERO = 1'b0,
  parameter int                             TBL_N      = 4,
  parameter logic [TBL_N-1:0][WIDTH-1:0]    TBL_VAL    = '0,
  parameter logic [TBL_N-1:0][DIV_W-1:0]    TBL_DIV    = '0
) (
  input  logic [WIDTH-1:0] field,
  output logic [DIV_W-1:0] div,
  output logic             byp,
  output logic             bad
);
  logic [DIV_W-1:0] raw_div;
  logic             raw_bad;
  logic             zero_byp;

  generate
    if (MODE == DEC_PLUS1) begin : g_plus1
      assign raw_div  = DIV_W'(field) + 1'b1;
      assign raw_bad  = 1'b0;
      assign zero_byp = 1'b0;
    end else if (MODE == DEC_ONEBASED) begin : g_onebased
      assign raw_div  = DIV_W'(field);
      assign raw_bad  = (field == '0) && !ALLOW_ZERO;
      assign zero_byp = (field == '0) && ALLOW_ZERO;
    end else if (MODE == DEC_POW2) begin : g_pow2
      logic too_big;
      assign too_big  = 32'(field) >= DIV_W;
      assign raw_div  = too_big ? '0 : (DIV_W'(1) << field);
      assign raw_bad  = too_big;
      assign zero_byp = 1'b0;
    end else begin : g_table
      logic [DIV_W-1:0] hit_div;
      logic             hit;
      logic             stop;
      always_comb begin
        hit     = 1'b0;
        stop    = 1'b0;
        hit_div = '0;
        for (int i = 0; i < TBL_N; i++) begin
          if (!stop) begin
            if (TBL_DIV[i] == '0) begin
              stop = 1'b1;
            end else if (!hit && TBL_VAL[i] == field) begin
              hit     = 1'b1;
              hit_div = TBL_DIV[i];
            end
          end
        end
      end
      assign raw_div  = hit_div;
      assign raw_bad  = !hit;
      assign zero_byp = 1'b0;
    end
  endgenerate

  assign bad = raw_bad;
  assign byp = !raw_bad && (zero_byp || raw_div == DIV_W'(1));
  assign div = (raw_bad || byp) ? '0 : raw_div;
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] new_div,
  input  logic             new_byp,
  input  logic             new_bad,
  output logic [DIV_W-1:0] cur_div,
  output logic             cur_byp,
  output logic             cur_bad,
  output logic             wrap,
  output logic             div_q
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_inc;
  logic             run;
  logic             new_run;

  assign run     = !cur_byp && !cur_bad && (cur_div > DIV_W'(1));
  assign new_run = !new_byp && !new_bad && (new_div > DIV_W'(1));
  assign wrap    = !run || (cnt_q == cur_div - 1'b1);
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cur_div <= '0;
      cur_byp <= 1'b0;
      cur_bad <= 1'b0;
      div_q   <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      cur_div <= new_div;
      cur_byp <= new_byp;
      cur_bad <= new_bad;
      div_q   <= new_run;
    end else begin
      cnt_q   <= cnt_inc;
      div_q   <= cnt_inc < (cur_div >> 1);
    end
  end
endmodule

// File: rtl/clkdiv_reg.sv
module clkdiv_reg
  import clkdiv_pkg::*;
#(
  parameter dec_mode_e                   MODE       = DEC_PLUS1,
  parameter int                          SHIFT      = 4,
  parameter int                          WIDTH      = 4,
  parameter int                          DIV_W      = 16,
  parameter bit                          ALLOW_ZERO = 1'b0,
  parameter bit                          HIWORD     = 1'b0,
  parameter bit                          READ_ONLY  = 1'b0,
  parameter logic [15:0]                 RST_VAL    = 16'h0000,
  parameter int                          TBL_N      = 4,
  parameter logic [TBL_N-1:0][WIDTH-1:0] TBL_VAL    = {4'd5, 4'd9, 4'd7, 4'd3},
  parameter logic [TBL_N-1:0][DIV_W-1:0] TBL_DIV    = {16'd6, 16'd0, 16'd2, 16'd5}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        clk_out,
  output logic        bad_cfg
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  dec_div;
  logic              dec_byp;
  logic              dec_bad;
  logic [DIV_W-1:0]  cur_div;
  logic              cur_byp;
  logic              wrap;
  logic              div_q;

  clkdiv_ctrl_reg #(
    .SHIFT(SHIFT), .WIDTH(WIDTH), .HIWORD(HIWORD),
    .READ_ONLY(READ_ONLY), .RST_VAL(RST_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  clkdiv_decode #(
    .MODE(MODE), .WIDTH(WIDTH), .DIV_W(DIV_W), .ALLOW_ZERO(ALLOW_ZERO),
    .TBL_N(TBL_N), .TBL_VAL(TBL_VAL), .TBL_DIV(TBL_DIV)
  ) u_dec (
    .field(ctrl_q[SHIFT +: WIDTH]), .div(dec_div), .byp(dec_byp), .bad(dec_bad)
  );

  clkdiv_gen #(.DIV_W(DIV_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .new_div(dec_div), .new_byp(dec_byp),
    .new_bad(dec_bad), .cur_div(cur_div), .cur_byp(cur_byp),
    .cur_bad(bad_cfg), .wrap(wrap), .div_q(div_q)
  );

  assign rd_data = {16'h0000, ctrl_q};
  assign clk_out = cur_byp ? clk : div_q;
endmodule

// File: rtl/clkdiv_reg_chk.sv
module clkdiv_reg_chk #(
  parameter int SHIFT     = 4,
  parameter int WIDTH     = 4,
  parameter int DIV_W     = 16,
  parameter bit HIWORD    = 1'b0,
  parameter bit READ_ONLY = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [15:0]      ctrl,
  input logic [DIV_W-1:0] cur_div,
  input logic             wrap,
  input logic             div_q,
  input logic             bad_cfg
);
  // R11
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_low_chk: assert (div_q == 1'b0);
    end
  end

  // R10
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_div) |-> $past(wrap));

  // R2
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cfg |-> !div_q);

  // R8
  hiword_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HIWORD && $past(wr_en)) |-> (((ctrl ^ $past(ctrl)) & ~$past(wr_data[31:16])) == 16'h0000));

  // R9
  ro_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    READ_ONLY |-> $stable(ctrl[SHIFT +: WIDTH]));
endmodule

bind clkdiv_reg clkdiv_reg_chk #(
  .SHIFT(SHIFT), .WIDTH(WIDTH), .DIV_W(DIV_W), .HIWORD(HIWORD), .READ_ONLY(READ_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl_q),
  .cur_div(cur_div), .wrap(wrap), .div_q(div_q), .bad_cfg(bad_cfg)
);

// File: tb/sim_clkdiv_reg.sv
module sim_clkdiv_reg;
  import clkdiv_pkg::*;

  localparam int NI = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] we = '0;
  logic [1:0]  be [NI];
  logic [31:0] wd [NI];
  logic [31:0] rd [NI];
  logic [NI-1:0] co, bd;
  logic [15:0] shadow [NI];
  int checks = 0;
  int errors = 0;

  // 250 MHz clock.
  always #2 clk = ~clk;

  // Per-instance masking configuration, kept separately from the RTL.
  bit hw_cfg [NI] = '{0, 1, 0, 0, 0, 0};
  bit ro_cfg [NI] = '{0, 0, 0, 0, 0, 1};

  clkdiv_reg #(.MODE(DEC_PLUS1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_be(be[0]), .wr_data(wd[0]),
    .rd_data(rd[0]), .clk_out(co[0]), .bad_cfg(bd[0]));
  clkdiv_reg #(.MODE(DEC_ONEBASED), .ALLOW_ZERO(1'b1), .HIWORD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(we[1]), .wr_be(be[1]), .wr_data(wd[1]),
    .rd_data(rd[1]), .clk_out(co[1]), .bad_cfg(bd[1]));
  clkdiv_reg #(.MODE(DEC_POW2)) u2 (
    .clk(clk), .rst_n(rst_n), .wr_en(we[2]), .wr_be(be[2]), .wr_data(wd[2]),
    .rd_data(rd[2]), .clk_out(co[2]), .bad_cfg(bd[2]));
  clkdiv_reg #(.MODE(DEC_TABLE)) u3 (
    .clk(clk), .rst_n(rst_n), .wr_en(we[3]), .wr_be(be[3]), .wr_data(wd[3]),
    .rd_data(rd[3]), .clk_out(co[3]), .bad_cfg(bd[3]));
  clkdiv_reg #(.MODE(DEC_ONEBASED)) u4 (
    .clk(clk), .rst_n(rst_n), .wr_en(we[4]), .wr_be(be[4]), .wr_data(wd[4]),
    .rd_data(rd[4]), .clk_out(co[4]), .bad_cfg(bd[4]));
  clkdiv_reg #(.MODE(DEC_PLUS1), .READ_ONLY(1'b1), .RST_VAL(16'h0030)) u5 (
    .clk(clk), .rst_n(rst_n), .wr_en(we[5]), .wr_be(be[5]), .wr_data(wd[5]),
    .rd_data(rd[5]), .clk_out(co[5]), .bad_cfg(bd[5]));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // Expected divisor: 0 means invalid, 1 means pass-through.
  function automatic int exp_div(input int i, input int f);
    case (i)
      0, 5: return f + 1;
      1:    return (f == 0) ? 1 : f;
      2:    return (f >= 16) ? 0 : (1 << f);
      3: begin
        if (f == 3) return 5;
        if (f == 7) return 2;
        return 0;
      end
      default: return f;
    endcase
  endfunction

  function automatic logic [15:0] model_wr(input int i, input logic [15:0] old,
                                           input logic [31:0] d, input logic [1:0] b);
    logic [15:0] m;
    m = hw_cfg[i] ? d[31:16] : {{8{b[1]}}, {8{b[0]}}};
    if (ro_cfg[i]) m = m & 16'hFF0F;
    return (old & ~m) | (d[15:0] & m);
  endfunction

  task automatic wr(input int i, input logic [31:0] d, input logic [1:0] b);
    @(negedge clk);
    we[i] = 1'b1; wd[i] = d; be[i] = b;
    @(negedge clk);
    we[i] = 1'b0;
    shadow[i] = model_wr(i, shadow[i], d, b);
  endtask

  task automatic measure(input int i, output int hi, output int lo);
    int n;
    hi = 0; lo = 0;
    n = 0;
    while (co[i] !== 1'b0 && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (co[i] !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    while (co[i] === 1'b1 && hi < 100) begin @(negedge clk); hi++; end
    while (co[i] === 1'b0 && lo < 100) begin @(negedge clk); lo++; end
  endtask

  task automatic check_out(input int i, input string tag);
    int n, hi, lo;
    n = exp_div(i, int'(shadow[i][7:4]));
    repeat (40) @(negedge clk);
    check(rd[i] == {16'h0, shadow[i]}, {tag, " R12 readback"}, int'(rd[i]), int'(shadow[i]));
    if (n == 0) begin
      check(bd[i] == 1'b1, {tag, " bad flag"}, int'(bd[i]), 1);
      hi = 0;
      repeat (8) begin @(posedge clk); #1; if (co[i] !== 1'b0) hi++; end
      check(hi == 0, {tag, " output low while invalid"}, hi, 0);
    end else if (n == 1) begin
      check(bd[i] == 1'b0, {tag, " bad flag"}, int'(bd[i]), 0);
      @(posedge clk); #1; hi = int'(co[i]);
      @(negedge clk); #1; lo = int'(co[i]);
      check(hi == 1 && lo == 0, {tag, " pass-through"}, hi * 2 + lo, 2);
    end else begin
      check(bd[i] == 1'b0, {tag, " bad flag"}, int'(bd[i]), 0);
      measure(i, hi, lo);
      check(hi == n / 2, {tag, " high length"}, hi, n / 2);
      check(hi + lo == n, {tag, " period"}, hi + lo, n);
    end
  endtask

  task automatic set_field(input int i, input int f, input string tag);
    logic [31:0] d;
    d = hw_cfg[i] ? {16'h00F0, 8'h00, 4'(f), 4'h0} : {16'h0, 8'h00, 4'(f), 4'h0};
    wr(i, d, 2'b11);
    check_out(i, tag);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo;
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < NI; i++) begin be[i] = 2'b00; wd[i] = '0; end
    shadow = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0030};

    // R11 reset state
    repeat (3) @(negedge clk);
    check(co[0] == 1'b0, "R11 clk_out low in reset", int'(co[0]), 0);
    check(rd[5] == 32'h0030, "R11 reset value", int'(rd[5]), 32'h30);
    rst_n = 1'b1;

    // R1 plus-one, random fields with other bits (R6)
    for (int k = 0; k < 12; k++) begin
      d = ($urandom & 32'h0000FF0F) | ($urandom_range(0, 15) << 4);
      wr(0, d, 2'b11);
      check_out(0, "R1 R6 plus-one");
    end
    set_field(0, 0, "R1 divisor one");
    set_field(0, 6, "R1 odd divisor 7");

    // R7 byte enables
    wr(0, 32'hFFFF_ABCD, 2'b01);
    check_out(0, "R7 low byte only");
    wr(0, 32'h0000_1234, 2'b10);
    check_out(0, "R7 high byte only");
    wr(0, 32'h0000_5555, 2'b00);
    check_out(0, "R7 no enable");

    // R10 divisor change mid-period
    set_field(0, 7, "R10 setup");
    while (co[0] !== 1'b0) @(negedge clk);
    while (co[0] !== 1'b1) @(negedge clk);
    we[0] = 1'b1; wd[0] = 32'h0000_0010; be[0] = 2'b11;
    hi = 1;
    @(negedge clk);
    we[0] = 1'b0;
    shadow[0] = model_wr(0, shadow[0], 32'h0000_0010, 2'b11);
    while (co[0] === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (co[0] === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    check(hi == 4 && lo == 4, "R10 old period completes", hi * 10 + lo, 44);
    measure(0, hi, lo);
    check(hi == 1 && hi + lo == 2, "R10 new divisor", hi * 10 + lo, 11);

    // R8 word-mask writes, one-based with zero allowed
    for (int k = 0; k < 10; k++) begin
      wr(1, $urandom, 2'b00);
      check_out(1, "R8 masked write");
    end
    wr(1, 32'h0000_FFFF, 2'b11);
    check_out(1, "R8 zero mask holds");
    set_field(1, 0, "R3 zero pass-through");
    set_field(1, 5, "R3 one-based five");

    // R4 power of two
    set_field(2, 0, "R4 pow2 zero");
    set_field(2, 1, "R4 pow2 one");
    set_field(2, 3, "R4 pow2 three");
    set_field(2, 5, "R4 pow2 five");

    // R5 table
    set_field(3, 3, "R5 table hit 3");
    set_field(3, 7, "R5 table hit 7");
    set_field(3, 9, "R5 terminator value");
    set_field(3, 5, "R5 after terminator");
    set_field(3, 0, "R5 missing value");

    // R2 one-based, zero invalid
    set_field(4, 0, "R2 zero invalid");
    set_field(4, 1, "R2 one pass-through");
    set_field(4, 6, "R2 six");
    set_field(4, 7, "R2 seven");

    // R9 read-only field
    check_out(5, "R9 reset divisor");
    wr(5, 32'h0000_5A0F, 2'b11);
    check_out(5, "R9 field frozen, rest written");
    check(rd[5] == 32'h0000_5A3F, "R9 readback", int'(rd[5]), 32'h5A3F);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule